// File: doc/BRIEF.md
# Multi-mode DMA address generator

This block computes the byte address for each successive element access on one side (read side or write side) of a DMA transfer. A load strobe captures a start address, an address mode, an element size code, the element count per frame, the frame count per block, two signed skips and a repeat count. From then on, every accept strobe means the current address has been consumed, and the block moves to the next one.

The block knows where each frame ends and where the block ends. It gives a one-cycle pulse at each frame end and at the block end. At the end of a block it returns to the start address. It can then run the same block again, either a set number of times or without limit. An abort input stops it at once. The block moves no data and drives no bus.

Top module: `dma_addr_gen`

## Requirements
- R1: While reset is applied and right after it, `addr` is 0 and `busy`, `frameDone` and `blockDone` are all 0.
- R2: When `load` is high while idle and `abort` is low, the next cycle shows `addr` equal to `startAddr` and `busy` high. The element size code is 0, 1, 2 or 3 and selects 1, 2, 4 or 8 bytes.
- R3: With mode code 0 (constant), accepts leave `addr` unchanged. The unused codes 5, 6 and 7 behave the same way.
- R4: Mode code 1 adds the element size to the address on each accept that does not end the block. Mode code 2 subtracts it. Addresses wrap modulo 2^32.
- R5: Mode code 3 adds the element size plus the signed two's-complement element skip on each accept that does not end the block.
- R6: Mode code 4 adds the element size plus the element skip inside a frame. On the accept of a frame's last element it adds the element size plus the element skip plus the signed frame skip.
- R7: `frameDone` is high for exactly the one cycle after the accept of the last element of each frame.
- R8: A block holds `elemPerFrame` × `framesPerBlock` accesses, and both counts must be at least 1. On the accept of the block's last access, `blockDone` pulses in the following cycle together with `frameDone`, and `addr` returns to the start address.
- R9: A repeat count of 0 runs the block once. A count n > 0 runs it n+1 times. A negative count (for example -1) runs it without limit. `busy` falls in the cycle after the final block ends.
- R10: A `load` while `busy` is high is ignored, and the running transfer continues unchanged.
- R11: `abort` takes priority over `load` and `accept`. It drops `busy` in the next cycle without a pulse, and a later `load` starts a new transfer.
- R12: An `accept` while idle changes nothing and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture the configuration and start |
| startAddr | input | 32 | First address of the block |
| addrMode | input | 3 | Address mode code |
| sizeCode | input | 2 | Element size as log2 of the byte count |
| elemPerFrame | input | 16 | Elements in one frame |
| framesPerBlock | input | 16 | Frames in one block |
| elemSkip | input | 16 | Signed extra stride after each element |
| frameSkip | input | 16 | Signed extra stride after each frame |
| repeatCount | input | 8 | Signed repeat count |
| accept | input | 1 | Current address has been consumed |
| abort | input | 1 | Stop the transfer |
| addr | output | 32 | Current access address |
| busy | output | 1 | Transfer active |
| frameDone | output | 1 | Frame completed, one-cycle pulse |
| blockDone | output | 1 | Block completed, one-cycle pulse |

## Verification
An element or frame counter that drifts by one has two visible effects. `frameDone` moves to the wrong accept, and in 2D mode the frame skip is applied to the wrong address. Both show up within one frame of the error. If the latched stride or mode is wrong, the very next accept produces a wrong `addr`. If the repeat counter is wrong, `busy` stays high or falls one block away from where it should, which is visible at the last block end. The reference model tracks all four outputs on every cycle, so any of these faults is flagged in the cycle where it first shows at the ports.

// File: rtl/dma_addr_gen_pkg.sv
package dma_addr_gen_pkg;
  typedef enum logic [2:0] {
    AG_CONST = 3'd0,
    AG_INC   = 3'd1,
    AG_DEC   = 3'd2,
    AG_IDX1  = 3'd3,
    AG_IDX2  = 3'd4
  } agMode_t;

  typedef struct packed {
    logic load;      // capture configuration, go to start address
    logic advance;   // step to next address
    logic restart;   // block finished, return to start address
    logic frameEnd;  // current element closes its frame
  } agStrobe_t;
endpackage

// File: rtl/dma_addr_gen_ctrl.sv
module dma_addr_gen_ctrl
  import dma_addr_gen_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REP_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             load,
  input  logic             accept,
  input  logic             abort,
  input  logic [CNT_W-1:0] elemPerFrame,
  input  logic [CNT_W-1:0] framesPerBlock,
  input  logic [REP_W-1:0] repeatCount,
  output agStrobe_t        strb,
  output logic             busy,
  output logic             frameDone,
  output logic             blockDone
);
  logic [CNT_W-1:0] elemCnt, frameCnt, epfReg, fpbReg;
  logic [REP_W-1:0] repLeft;
  logic lastElem, lastFrame, step;

  always_comb begin
    lastElem      = (elemCnt == CNT_W'(epfReg - 1'b1));
    lastFrame     = (frameCnt == CNT_W'(fpbReg - 1'b1));
    step          = busy && accept && !abort;
    strb.load     = load && !busy && !abort;
    strb.advance  = step && !(lastElem && lastFrame);
    strb.restart  = step && lastElem && lastFrame;
    strb.frameEnd = lastElem;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy <= 1'b0; frameDone <= 1'b0; blockDone <= 1'b0;
      elemCnt <= '0; frameCnt <= '0; epfReg <= '0; fpbReg <= '0; repLeft <= '0;
    end else begin
      frameDone <= 1'b0;
      blockDone <= 1'b0;
      if (abort) begin
        busy <= 1'b0; elemCnt <= '0; frameCnt <= '0;
      end else if (strb.load) begin
        busy <= 1'b1; elemCnt <= '0; frameCnt <= '0;
        epfReg <= elemPerFrame; fpbReg <= framesPerBlock; repLeft <= repeatCount;
      end else if (step) begin
        frameDone <= lastElem;
        blockDone <= lastElem && lastFrame;
        if (lastElem) begin
          elemCnt <= '0;
          frameCnt <= lastFrame ? '0 : frameCnt + 1'b1;
        end else begin
          elemCnt <= elemCnt + 1'b1;
        end
        if (lastElem && lastFrame) begin
          if (repLeft == '0) busy <= 1'b0;
          else if (!repLeft[REP_W-1]) repLeft <= repLeft - 1'b1;
        end
      end
    end
  end

  p_abort_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    abort |=> (!busy && !frameDone && !blockDone));
  p_load_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && load && !abort && !accept) |=> busy);
  p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    !busy |=> (!frameDone && !blockDone));
  p_block_is_frame_r8: assert property (@(posedge clk) disable iff (!rstN)
    blockDone |-> frameDone);
endmodule

// File: rtl/dma_addr_gen_dp.sv
module dma_addr_gen_dp
  import dma_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SKIP_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  agStrobe_t         strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        addrMode,
  input  logic [1:0]        sizeCode,
  input  logic [SKIP_W-1:0] elemSkip,
  input  logic [SKIP_W-1:0] frameSkip,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - SKIP_W;

  agMode_t           modeReg;
  logic [1:0]        sizeReg;
  logic [ADDR_W-1:0] startReg, sizeBytes, eskExt, fskExt, stride;

  always_comb begin
    sizeBytes = ADDR_W'(1) << sizeReg;
    eskExt    = {{EXT_W{elemSkipReg[SKIP_W-1]}}, elemSkipReg};
    fskExt    = {{EXT_W{frameSkipReg[SKIP_W-1]}}, frameSkipReg};
    case (modeReg)
      AG_INC:  stride = sizeBytes;
      AG_DEC:  stride = -sizeBytes;
      AG_IDX1: stride = sizeBytes + eskExt;
      AG_IDX2: stride = sizeBytes + eskExt + (strb.frameEnd ? fskExt : '0);
      default: stride = '0;
    endcase
  end

  logic [SKIP_W-1:0] elemSkipReg, frameSkipReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addr <= '0; startReg <= '0; modeReg <= AG_CONST; sizeReg <= '0;
      elemSkipReg <= '0; frameSkipReg <= '0;
    end else if (strb.load) begin
      addr <= startAddr; startReg <= startAddr; modeReg <= agMode_t'(addrMode);
      sizeReg <= sizeCode; elemSkipReg <= elemSkip; frameSkipReg <= frameSkip;
    end else if (strb.restart) begin
      addr <= startReg;
    end else if (strb.advance) begin
      addr <= addr + stride;
    end
  end

  p_const_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg == AG_CONST && !strb.load) |=> addr == $past(addr));
  p_no_strobe_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.load && !strb.advance && !strb.restart) |=> $stable(addr));
  p_restart_start_r8: assert property (@(posedge clk) disable iff (!rstN)
    strb.restart |=> addr == startReg);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
  import dma_addr_gen_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int SKIP_W = 16,
  parameter int REP_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [2:0]        addrMode,
  input  logic [1:0]        sizeCode,
  input  logic [CNT_W-1:0]  elemPerFrame,
  input  logic [CNT_W-1:0]  framesPerBlock,
  input  logic [SKIP_W-1:0] elemSkip,
  input  logic [SKIP_W-1:0] frameSkip,
  input  logic [REP_W-1:0]  repeatCount,
  input  logic              accept,
  input  logic              abort,
  output logic [ADDR_W-1:0] addr,
  output logic              busy,
  output logic              frameDone,
  output logic              blockDone
);
  agStrobe_t strb;

  dma_addr_gen_ctrl #(.CNT_W(CNT_W), .REP_W(REP_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .load(load), .accept(accept), .abort(abort),
    .elemPerFrame(elemPerFrame), .framesPerBlock(framesPerBlock),
    .repeatCount(repeatCount), .strb(strb), .busy(busy),
    .frameDone(frameDone), .blockDone(blockDone)
  );

  dma_addr_gen_dp #(.ADDR_W(ADDR_W), .SKIP_W(SKIP_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .startAddr(startAddr),
    .addrMode(addrMode), .sizeCode(sizeCode), .elemSkip(elemSkip),
    .frameSkip(frameSkip), .addr(addr)
  );
endmodule

// File: tb/dma_addr_gen_tb.sv
module dma_addr_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic load = 0, accept = 0, abort = 0;
  logic [31:0] startAddr = 0;
  logic [2:0]  addrMode = 0;
  logic [1:0]  sizeCode = 0;
  logic [15:0] elemPerFrame = 1, framesPerBlock = 1, elemSkip = 0, frameSkip = 0;
  logic [7:0]  repeatCount = 0;
  logic [31:0] addr;
  logic busy, frameDone, blockDone;

  int checks = 0, errors = 0;
  string curReq = "R1";

  // reference model state
  logic [31:0] mAddr, mStart;
  logic mBusy, mFd, mBd;
  int mMode, mSize, mEpf, mFpb, mEs, mFs, mRep, mEc, mFc;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_addr_gen dut_i (
    .clk(clk), .rstN(rstN), .load(load), .startAddr(startAddr), .addrMode(addrMode),
    .sizeCode(sizeCode), .elemPerFrame(elemPerFrame), .framesPerBlock(framesPerBlock),
    .elemSkip(elemSkip), .frameSkip(frameSkip), .repeatCount(repeatCount),
    .accept(accept), .abort(abort), .addr(addr), .busy(busy),
    .frameDone(frameDone), .blockDone(blockDone)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mAddr = 0; mStart = 0; mBusy = 0; mFd = 0; mBd = 0; mEc = 0; mFc = 0;
      mMode = 0; mSize = 1; mEpf = 1; mFpb = 1; mEs = 0; mFs = 0; mRep = 0;
    end else begin
      mFd = 0; mBd = 0;
      if (abort) begin
        mBusy = 0; mEc = 0; mFc = 0;
      end else if (!mBusy) begin
        if (load) begin
          mStart = startAddr; mAddr = startAddr; mBusy = 1; mEc = 0; mFc = 0;
          mMode = int'(addrMode); mSize = 1 << sizeCode;
          mEpf = int'(elemPerFrame); mFpb = int'(framesPerBlock);
          mEs = int'($signed(elemSkip)); mFs = int'($signed(frameSkip));
          mRep = int'($signed(repeatCount));
        end
      end else if (accept) begin
        bit le, lf; int st;
        le = (mEc == mEpf - 1); lf = (mFc == mFpb - 1);
        mFd = le; mBd = le && lf;
        if (le && lf) begin
          mEc = 0; mFc = 0; mAddr = mStart;
          if (mRep == 0) mBusy = 0;
          else if (mRep > 0) mRep = mRep - 1;
        end else begin
          case (mMode)
            1: st = mSize;
            2: st = -mSize;
            3: st = mSize + mEs;
            4: st = mSize + mEs + (le ? mFs : 0);
            default: st = 0;
          endcase
          mAddr = mAddr + st;
          if (le) begin mEc = 0; mFc = mFc + 1; end
          else mEc = mEc + 1;
        end
      end
    end
  end

  always @(negedge clk) begin
    checks += 4;
    if (addr !== mAddr) begin errors++;
      $display("FAIL %s addr: actual=%h expected=%h t=%0t", curReq, addr, mAddr, $time); end
    if (busy !== mBusy) begin errors++;
      $display("FAIL %s busy: actual=%b expected=%b t=%0t", curReq, busy, mBusy, $time); end
    if (frameDone !== mFd) begin errors++;
      $display("FAIL R7 frameDone (%s): actual=%b expected=%b t=%0t", curReq, frameDone, mFd, $time); end
    if (blockDone !== mBd) begin errors++;
      $display("FAIL R8 blockDone (%s): actual=%b expected=%b t=%0t", curReq, blockDone, mBd, $time); end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic doLoad(logic [31:0] sa, int md, int sc, int epf, int fpb,
                        int es, int fs, int rep);
    @(negedge clk); #1;
    startAddr = sa; addrMode = 3'(md); sizeCode = 2'(sc);
    elemPerFrame = 16'(epf); framesPerBlock = 16'(fpb);
    elemSkip = 16'(es); frameSkip = 16'(fs); repeatCount = 8'(rep); load = 1;
    @(negedge clk); #1; load = 0;
  endtask

  task automatic doAccept(int n, bit gaps);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1; accept = 1;
      if (gaps) begin @(negedge clk); #1; accept = 0; end
    end
    @(negedge clk); #1; accept = 0;
  endtask

  initial begin
    curReq = "R1"; tick(3); rstN = 1; tick(2);
    curReq = "R12"; doAccept(4, 0); tick(1);
    curReq = "R2"; doLoad(32'h100, 1, 2, 3, 2, 0, 0, 0);
    curReq = "R4"; doAccept(6, 0); tick(2);
    curReq = "R4"; doLoad(32'h2, 2, 3, 4, 1, 0, 0, 0); doAccept(4, 1); tick(1);
    curReq = "R3"; doLoad(32'h55, 0, 1, 2, 2, 7, 9, 0); doAccept(4, 0);
    doLoad(32'h77, 6, 2, 3, 1, 5, 5, 0); doAccept(3, 0); tick(1);
    curReq = "R5"; doLoad(32'h1000, 3, 1, 5, 1, -3, 0, 0); doAccept(5, 0); tick(1);
    curReq = "R6"; doLoad(32'h4000, 4, 2, 3, 3, 4, -20, 0); doAccept(9, 1); tick(1);
    curReq = "R9"; doLoad(32'h80, 1, 0, 2, 2, 0, 0, 2); doAccept(12, 0); tick(2);
    curReq = "R10"; doLoad(32'h200, 1, 1, 4, 1, 0, 0, 0); doAccept(1, 0);
    doLoad(32'hABC, 2, 3, 1, 1, 0, 0, 0); doAccept(3, 0); tick(1);
    curReq = "R11"; doLoad(32'h300, 3, 0, 2, 3, 1, 0, -1); doAccept(20, 0);
    @(negedge clk); #1; abort = 1; accept = 1; load = 1;
    @(negedge clk); #1; abort = 0; accept = 0; load = 0; tick(1);
    doLoad(32'h900, 4, 1, 2, 2, 0, 8, 1); doAccept(3, 0);
    @(negedge clk); #1; abort = 1; @(negedge clk); #1; abort = 0;
    doAccept(2, 0); tick(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule